// File: doc/BRIEF.md
# Linked Sort List Walker

This block follows a table of link entries held in memory and turns it into a stream of data block addresses for a downstream fetch unit. After a start strobe it reads table entries one at a time, starting at a table base address. Each entry is read as a 16-bit or a 32-bit value, depending on a width select. The walker treats each entry as a control code or as a link. A link is scaled and added to a data base address, and the result goes out on a valid/ready stream. One reserved code closes the current list and bumps a list counter. Another reserved code ends the walk and fires a one-cycle done pulse.

The table base, data base, entry width and address scaling are captured when the walk starts. The list count stays readable after the walk ends, until the next start. Fetching and processing the block contents is left to the consumer of the address stream.

Top module: `sort_walker`

## Requirements
- R1: After reset the walker is idle: `rd_req_o`, `blk_valid_o` and `done_o` are low and `count_o` is 0.
- R2: A start in idle captures the configuration. Reads begin at `tbl_base_i` and advance by 2 bytes when `wide_i` was 0, or by 4 bytes when it was 1. With 16-bit entries only `rd_data_i[15:0]` is used and bits 31:16 are ignored.
- R3: Each entry is cut to its low 27 bits before it is classified, so set bits 31:27 change neither the code nor the link.
- R4: An entry whose masked value is 1 emits no block, adds one to `count_o`, and reads the next entry.
- R5: An entry whose masked value is 2 ends the walk. `done_o` goes high for exactly one cycle, the walker returns to idle, and `count_o` then holds its value.
- R6: Any other masked value L emits the block address `data_base + (L << 5)` when `shift_i` was 1 at start, or `data_base + L` otherwise, computed modulo 2^32.
- R7: `count_o` is set to 1 when a walk starts.
- R8: A block address stays valid and unchanged until `blk_ready_i` accepts it. No table read is requested while an address waits.
- R9: `start_i` has no effect while a walk is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a walk (idle only) |
| tbl_base_i | input | 32 | Byte address of the first table entry |
| data_base_i | input | 32 | Base added to every scaled link |
| wide_i | input | 1 | 1: 32-bit entries, 0: 16-bit entries |
| shift_i | input | 1 | 1: link scaled by 32, 0: unscaled |
| rd_req_o | output | 1 | Table read request, held until answered |
| rd_addr_o | output | 32 | Byte address of the requested entry |
| rd_valid_i | input | 1 | Read response valid; completes the request |
| rd_data_i | input | 32 | Read response data |
| blk_valid_o | output | 1 | Block address valid |
| blk_ready_i | input | 1 | Consumer accepts the block address |
| blk_addr_o | output | 32 | Block address |
| count_o | output | 16 | Lists traversed in the current or last walk |
| done_o | output | 1 | One-cycle end-of-walk pulse |

## Verification
Two kinds of event can fall in the same cycle: a start strobe arriving while a walk is busy, and the list count advancing on a list-end code. The bench pulses `start_i` in the middle of a table full of list-end codes, so a wrongly accepted start would reset the count or restart the reads. It then checks that the final count and the address stream match the table model. The back-pressure check runs under varying ready patterns: every cycle in which an address waits is judged for a stable address and an idle read port.

// File: rtl/sort_walker_pkg.sv
package sort_walker_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_EMIT} walk_state_e;
  typedef enum logic [1:0] {ENT_LINK, ENT_NEXT_LIST, ENT_END} entry_kind_e;
  localparam int unsigned CODE_NEXT_LIST = 1;
  localparam int unsigned CODE_END       = 2;
endpackage

// File: rtl/sort_walker_decode.sv
module sort_walker_decode
  import sort_walker_pkg::*;
#(
  parameter int RD_W     = 32,
  parameter int NARROW_W = 16,
  parameter int LINK_W   = 27
) (
  input  logic [RD_W-1:0]   raw_i,
  input  logic              wide_i,
  output entry_kind_e       kind_o,
  output logic [LINK_W-1:0] link_o
);
  logic [RD_W-1:0] ext;

  always_comb begin
    ext = wide_i ? raw_i : RD_W'(raw_i[NARROW_W-1:0]);
    link_o = ext[LINK_W-1:0];
    if (link_o == LINK_W'(CODE_NEXT_LIST))  kind_o = ENT_NEXT_LIST;
    else if (link_o == LINK_W'(CODE_END))   kind_o = ENT_END;
    else                                    kind_o = ENT_LINK;
  end
endmodule

// File: rtl/sort_walker_fetch.sv
module sort_walker_fetch #(
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic              advance_i,
  input  logic              wide_i,
  output logic [ADDR_W-1:0] ptr_o
);
  localparam logic [ADDR_W-1:0] STEP_W = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] STEP_N = ADDR_W'(2);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ptr_o <= '0;
    else if (load_i)    ptr_o <= base_i;
    else if (advance_i) ptr_o <= ptr_o + (wide_i ? STEP_W : STEP_N);
  end
endmodule

// File: rtl/sort_walker_addr_gen.sv
module sort_walker_addr_gen #(
  parameter int ADDR_W    = 32,
  parameter int LINK_W    = 27,
  parameter int SHIFT_AMT = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [LINK_W-1:0] link_i,
  input  logic              shift_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] link_ext, scaled;

  generate
    if (SHIFT_AMT > 0) begin : g_shift
      always_comb begin
        link_ext = ADDR_W'(link_i);
        scaled   = shift_i ? (link_ext << SHIFT_AMT) : link_ext;
      end
    end else begin : g_flat
      always_comb begin
        link_ext = ADDR_W'(link_i);
        scaled   = link_ext;
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     addr_o <= '0;
    else if (load_i) addr_o <= base_i + scaled;
  end
endmodule

// File: rtl/sort_walker.sv
module sort_walker
  import sort_walker_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int RD_W      = 32,
  parameter int LINK_W    = 27,
  parameter int CNT_W     = 16,
  parameter int SHIFT_AMT = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] tbl_base_i,
  input  logic [ADDR_W-1:0] data_base_i,
  input  logic              wide_i,
  input  logic              shift_i,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic              rd_valid_i,
  input  logic [RD_W-1:0]   rd_data_i,
  output logic              blk_valid_o,
  input  logic              blk_ready_i,
  output logic [ADDR_W-1:0] blk_addr_o,
  output logic [CNT_W-1:0]  count_o,
  output logic              done_o
);
  localparam int NARROW_W = RD_W / 2;

  walk_state_e       state_q;
  logic              wide_q, shift_q;
  logic [ADDR_W-1:0] data_base_q;
  entry_kind_e       kind;
  logic [LINK_W-1:0] link;
  logic              start_evt, accept;

  assign start_evt = (state_q == ST_IDLE) && start_i;
  assign accept    = (state_q == ST_FETCH) && rd_valid_i;
  assign rd_req_o    = (state_q == ST_FETCH);
  assign blk_valid_o = (state_q == ST_EMIT);

  sort_walker_decode #(.RD_W(RD_W), .NARROW_W(NARROW_W), .LINK_W(LINK_W)) u_decode (
    .raw_i  (rd_data_i),
    .wide_i (wide_q),
    .kind_o (kind),
    .link_o (link)
  );

  sort_walker_fetch #(.ADDR_W(ADDR_W)) u_fetch (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (start_evt),
    .base_i    (tbl_base_i),
    .advance_i (accept),
    .wide_i    (wide_q),
    .ptr_o     (rd_addr_o)
  );

  sort_walker_addr_gen #(.ADDR_W(ADDR_W), .LINK_W(LINK_W), .SHIFT_AMT(SHIFT_AMT)) u_addr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (accept && kind == ENT_LINK),
    .base_i  (data_base_q),
    .link_i  (link),
    .shift_i (shift_q),
    .addr_o  (blk_addr_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      wide_q      <= 1'b0;
      shift_q     <= 1'b0;
      data_base_q <= '0;
      count_o     <= '0;
      done_o      <= 1'b0;
    end else begin
      done_o <= accept && kind == ENT_END;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q     <= ST_FETCH;
          wide_q      <= wide_i;
          shift_q     <= shift_i;
          data_base_q <= data_base_i;
          count_o     <= CNT_W'(1);
        end
        ST_FETCH: if (rd_valid_i) begin
          unique case (kind)
            ENT_NEXT_LIST: count_o <= count_o + CNT_W'(1);
            ENT_END:       state_q <= ST_IDLE;
            default:       state_q <= ST_EMIT;
          endcase
        end
        ST_EMIT: if (blk_ready_i) state_q <= ST_FETCH;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blk_valid_o && !blk_ready_i |=> blk_valid_o && $stable(blk_addr_o));
  assert_no_read_in_emit_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blk_valid_o |-> !rd_req_o);
  assert_done_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_count_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && !start_i) |=> $stable(count_o));
  assert_busy_start_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_EMIT && start_i) |=> $stable(count_o) && $stable(rd_addr_o));
  assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !rd_req_o && !blk_valid_o);
endmodule

// File: tb/sort_walker_bench.sv
module sort_walker_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 16;
  localparam int NSC  = 4;
  localparam logic [31:0] VEC [NVEC] = '{
    32'h0000_0003, 32'h0000_0001, 32'h0000_7FFF, 32'h0000_0001, 32'h0000_0002,
    32'hF800_0004, 32'hFFFF_FFF1, 32'h0000_0001, 32'h0800_0002, 32'h0000_0005,
    32'h0000_0001, 32'h0000_0001, 32'h0000_0001, 32'h0000_0040, 32'h07FF_FFFF,
    32'h0000_0002};
  localparam logic        SC_WIDE  [NSC] = '{1'b0, 1'b1, 1'b0, 1'b1};
  localparam logic        SC_SHIFT [NSC] = '{1'b0, 1'b1, 1'b1, 1'b0};
  localparam logic [31:0] SC_TBASE [NSC] = '{32'h000, 32'h040, 32'h082, 32'h0C0};
  localparam logic [31:0] SC_DBASE [NSC] = '{32'h1000_0000, 32'h2000_0000, 32'h0000_0100, 32'hFFFF_FF00};
  localparam int          SC_IDX   [NSC] = '{0, 5, 10, 10};
  localparam int          SC_LEN   [NSC] = '{5, 5, 6, 6};

  logic clk = 0, rst_ni = 0, start_i = 0, wide_i = 0, shift_i = 0;
  logic [31:0] tbl_base_i = 0, data_base_i = 0, rd_addr_o, rd_data_i = 0, blk_addr_o;
  logic rd_req_o, rd_valid_i = 0, blk_valid_o, blk_ready_i = 0, done_o;
  logic [15:0] count_o;

  sort_walker u_sort_walker (.clk_i(clk), .rst_ni, .start_i, .tbl_base_i, .data_base_i,
    .wide_i, .shift_i, .rd_req_o, .rd_addr_o, .rd_valid_i, .rd_data_i, .blk_valid_o,
    .blk_ready_i, .blk_addr_o, .count_o, .done_o);

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_bad = 0, cyc = 0, ready_mode = 0, got_n = 0, done_n = 0, stall_bad = 0;
  logic [15:0] mem [256];
  logic [31:0] got [32];
  logic [31:0] exp_a [32];
  logic [31:0] last_addr = 0;
  logic was_stall = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory responder: answers one cycle after a request is seen
  always @(negedge clk) begin
    if (rd_req_o && !rd_valid_i) begin
      rd_valid_i <= 1'b1;
      rd_data_i  <= {mem[8'(rd_addr_o[8:1] + 8'd1)], mem[rd_addr_o[8:1]]};
    end else rd_valid_i <= 1'b0;
  end

  // consumer with selectable ready pattern; R8 checks during stalls
  always @(negedge clk) begin
    cyc++;
    if (done_o) done_n++;
    if (was_stall && blk_valid_o && blk_addr_o !== last_addr) stall_bad++;
    if (blk_valid_o && rd_req_o) stall_bad++;
    case (ready_mode)
      0: blk_ready_i = 1'b1;
      1: blk_ready_i = (cyc % 3) == 0;
      default: blk_ready_i = (cyc % 7) == 0;
    endcase
    if (blk_valid_o && blk_ready_i && got_n < 32) begin
      got[got_n] = blk_addr_o;
      got_n++;
    end
    was_stall = blk_valid_o && !blk_ready_i;
    last_addr = blk_addr_o;
  end

  task automatic run_scn(input int s, input bit mid_start);
    int exp_n = 0, exp_cnt = 1, wd = 0;
    logic [31:0] v;
    for (int i = 0; i < 256; i++) mem[i] = 16'hFFFF;
    for (int i = 0; i < SC_LEN[s]; i++) begin
      if (SC_WIDE[s]) begin
        mem[(SC_TBASE[s] >> 1) + 2*i]     = VEC[SC_IDX[s]+i][15:0];
        mem[(SC_TBASE[s] >> 1) + 2*i + 1] = VEC[SC_IDX[s]+i][31:16];
      end else mem[(SC_TBASE[s] >> 1) + i] = VEC[SC_IDX[s]+i][15:0];
    end
    for (int i = 0; i < SC_LEN[s]; i++) begin
      v = SC_WIDE[s] ? VEC[SC_IDX[s]+i] : {16'h0, VEC[SC_IDX[s]+i][15:0]};
      v = v & 32'h07FF_FFFF;
      if (v == 1) exp_cnt++;
      else if (v == 2) break;
      else begin
        exp_a[exp_n] = SC_DBASE[s] + (SC_SHIFT[s] ? (v << 5) : v);
        exp_n++;
      end
    end
    @(negedge clk);
    got_n = 0; done_n = 0; stall_bad = 0; ready_mode = s % 3;
    wide_i = SC_WIDE[s]; shift_i = SC_SHIFT[s];
    tbl_base_i = SC_TBASE[s]; data_base_i = SC_DBASE[s]; start_i = 1;
    @(negedge clk);
    start_i = 0;
    // R2: first request at the table base
    check("R2 first read address", rd_addr_o, SC_TBASE[s]);
    wide_i = ~wide_i; shift_i = ~shift_i; data_base_i = 32'h5555_0000;
    while (done_n == 0 && wd < 2000) begin
      @(negedge clk);
      wd++;
      start_i = mid_start && (wd % 4 == 0);
      if (mid_start && wd % 4 == 0) tbl_base_i = 32'h0;
    end
    start_i = 0;
    if (wd >= 2000) check("R5 watchdog", 32'd0, 32'd1);
    repeat (3) @(negedge clk);
    check("R5 single done pulse", 32'(done_n), 32'd1);
    check("R4 R7 list count", 32'(count_o), 32'(exp_cnt));
    check("R5 idle after end", {30'd0, rd_req_o, blk_valid_o}, 32'd0);
    check("R6 block count", 32'(got_n), 32'(exp_n));
    for (int i = 0; i < exp_n; i++) check("R3 R6 block address", got[i], exp_a[i]);
    check("R8 stall stability", 32'(stall_bad), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset req", {31'd0, rd_req_o}, 32'd0);
    rst_ni = 1;
    @(negedge clk);
    check("R1 idle outputs", {29'd0, rd_req_o, blk_valid_o, done_o}, 32'd0);
    check("R1 idle count", 32'(count_o), 32'd0);
    for (int s = 0; s < NSC; s++) run_scn(s, 1'b0);
    // R9: repeated start strobes during a busy walk
    run_scn(2, 1'b1);
    run_scn(3, 1'b1);
    // R5: count holds in idle
    repeat (5) @(negedge clk);
    check("R5 count holds", 32'(count_o), 32'd4);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule